// File: doc/BRIEF.md
# Streaming Sobel Edge Magnitude Filter

This block takes an 8-bit grayscale frame as a stream of pixels in raster order. The stream runs row by row, and left to right within each row. For every input pixel it returns one 8-bit edge-strength pixel, in the same raster order. Two internal line stores, each one image row deep, hold the two rows above the incoming pixel. Together with two registered columns, they form a 3x3 neighbourhood around the pixel one row up and one column left of the newest input. The horizontal and vertical Sobel derivatives of that neighbourhood are formed in signed arithmetic. The factor of two is a one-bit shift, so no multiplier is needed. The magnitude is approximated as the sum of the two absolute values, shifted right and truncated to the pixel width.

Both ports use a valid/ready handshake. A stall on the output freezes the whole pipeline. The result for a pixel is ready once the pixel below-right of it has been accepted, so the output trails the input by one row plus one pixel. Every pixel on the outer frame ring has an incomplete neighbourhood and is sent as zero. After the last input of a frame, the block refuses input while it emits the remaining zero-valued ring pixels. It then accepts the next frame. Image width, height, pixel width and the magnitude shift are parameters.

Top module: `sobel_edge_stream`

## Requirements
- R1: For an interior pixel at row r, column c, let t, m and b be the rows r-1, r and r+1, and let L and R be the columns c-1 and c+1. Then Dx = (t[R] + 2*m[R] + b[R]) - (t[L] + 2*m[L] + b[L]). Dy = (t[L] + 2*t[c] + t[R]) - (b[L] + 2*b[c] + b[R]). The output pixel is ((|Dx| + |Dy|) >> MAG_SHIFT) truncated to PIX_W bits.
- R2: Every output pixel in row 0, row IMG_H-1, column 0 or column IMG_W-1 is 0.
- R3: A frame yields exactly IMG_W*IMG_H outputs in raster order. `out_sof` is 1 only on the first output of a frame, and `out_eol` is 1 exactly on outputs in column IMG_W-1. The input flags are expected on the same positions of the input stream.
- R4: An output transfers when `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sof` and `out_eol` hold their values into the next cycle.
- R5: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0.
- R6: After the last pixel of a frame is accepted, `in_ready` stays 0 until the final output of that frame has been loaded into the output register.
- R7: The output at raster index k is produced no earlier than the acceptance of input index k+IMG_W+1. While a frame's input is in progress, an accepted output k therefore needs at least k+IMG_W+2 accepted inputs.
- R8: A synchronous active-low reset clears `out_valid`, returns all position counters to the start of a frame and raises `in_ready`. After reset, the next accepted pixel is treated as row 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel is present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_data | input | PIX_W | Input grayscale pixel, 0 black, all ones white |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_eol | input | 1 | Marks the last pixel of a row |
| out_valid | output | 1 | Output pixel is present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | PIX_W | Edge magnitude pixel |
| out_sof | output | 1 | Marks the first output of a frame |
| out_eol | output | 1 | Marks the last output of a row |

## Verification
The framing checks assume that `in_sof` arrives only with the pixel the block counts as row 0, column 0. They also assume that `in_eol` arrives exactly on the last column. They further assume that no new frame is offered before the previous frame's outputs have drained. The stimulus meets these assumptions by deriving both flags from its own pixel index. During the flush gap it offers dummy data only while more than one output is still owed, and it holds the input idle otherwise. Handshake stalls on either side come from a free-running pseudo-random sequence, so hold and backpressure behaviour is exercised at irregular points inside rows and across frame boundaries.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

   // Side of the square neighbourhood and the rows that must be stored.
   localparam int WIN_SIDE  = 3;
   localparam int LINE_CNT  = WIN_SIDE - 1;

   // Stream phase: taking pixels, or draining the trailing zero ring.
   typedef enum logic {
      PH_FEED  = 1'b0,
      PH_FLUSH = 1'b1
   } sobel_phase_e;

endpackage

// File: rtl/sobel_line_store.sv
module sobel_line_store #(
   parameter int IMG_W = 600,
   parameter int PIX_W = 8,
   parameter int LINES = 2,
   localparam int CW   = $clog2(IMG_W)
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [CW-1:0]                col,
   input  logic [PIX_W-1:0]             pix_in,
   output logic [LINES-1:0][PIX_W-1:0]  taps
);

   if (LINES < 1) begin : g_bad_lines
      $error("sobel_line_store: LINES must be at least 1");
   end

   // Line k holds the row k+1 above the incoming pixel; each write
   // pushes the column one row further up the chain.
   for (genvar k = 0; k < LINES; k++) begin : g_line
      logic [PIX_W-1:0] mem [IMG_W];
      logic [PIX_W-1:0] src;

      if (k == 0) begin : g_head
         assign src = pix_in;
      end else begin : g_chain
         assign src = taps[k-1];
      end

      assign taps[k] = mem[col];

      always_ff @(posedge clk) begin
         if (wr_en) begin
            mem[col] <= src;
         end
      end
   end

endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel #(
   parameter int PIX_W     = 8,
   parameter int MAG_SHIFT = 3,
   localparam int D_W      = PIX_W + 3,
   localparam int M_W      = D_W + 1
) (
   // win[row][col]: row 0 is top, col 0 is left.
   input  logic [2:0][2:0][PIX_W-1:0] win,
   output logic [PIX_W-1:0]           mag
);

   if (MAG_SHIFT < 0 || MAG_SHIFT >= M_W) begin : g_bad_shift
      $error("sobel_kernel: MAG_SHIFT out of range");
   end

   logic signed [D_W-1:0] hdiff [3];
   logic signed [D_W-1:0] vdiff [3];

   // Per row: right minus left; per column: top minus bottom.
   // The centre row/column carries weight two via a single shift.
   for (genvar g = 0; g < 3; g++) begin : g_tap
      localparam int WT = (g == 1) ? 1 : 0;
      assign hdiff[g] = ($signed(D_W'(win[g][2])) - $signed(D_W'(win[g][0]))) <<< WT;
      assign vdiff[g] = ($signed(D_W'(win[0][g])) - $signed(D_W'(win[2][g]))) <<< WT;
   end

   logic signed [D_W-1:0] dx, dy;
   logic        [D_W-1:0] abs_dx, abs_dy;
   logic        [M_W-1:0] sum, scaled;

   always_comb begin
      dx     = hdiff[0] + hdiff[1] + hdiff[2];
      dy     = vdiff[0] + vdiff[1] + vdiff[2];
      abs_dx = dx[D_W-1] ? D_W'(-dx) : D_W'(dx);
      abs_dy = dy[D_W-1] ? D_W'(-dy) : D_W'(dy);
      sum    = {1'b0, abs_dx} + {1'b0, abs_dy};
      scaled = sum >> MAG_SHIFT;
      mag    = scaled[PIX_W-1:0];
   end

endmodule

// File: rtl/sobel_raster_ctl.sv
module sobel_raster_ctl
   import sobel_pkg::*;
#(
   parameter int IMG_W = 600,
   parameter int IMG_H = 400,
   localparam int CW   = $clog2(IMG_W),
   localparam int RW   = $clog2(IMG_H)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sof,
   input  logic          in_eol,
   input  logic          out_ready,
   input  logic          out_busy,
   output logic          in_ready,
   output logic          take,
   output logic          adv,
   output logic          emit,
   output logic          emit_zero,
   output logic          emit_sof,
   output logic          emit_eol,
   output logic [CW-1:0] in_col
);

   logic [CW-1:0] icol, ocol;
   logic [RW-1:0] irow, orow;
   sobel_phase_e  phase;

   logic in_last_col, in_last, has_out;
   logic o_last_col, o_last_row, o_last;

   always_comb begin
      in_last_col = (icol == CW'(IMG_W - 1));
      in_last     = in_last_col && (irow == RW'(IMG_H - 1));
      // First input that completes a neighbourhood is index IMG_W+1.
      has_out     = (irow >= RW'(2)) || ((irow == RW'(1)) && (icol != '0));
      o_last_col  = (ocol == CW'(IMG_W - 1));
      o_last_row  = (orow == RW'(IMG_H - 1));
      o_last      = o_last_col && o_last_row;

      adv       = !out_busy || out_ready;
      in_ready  = adv && (phase == PH_FEED);
      take      = in_valid && in_ready;
      emit      = (take && has_out) || ((phase == PH_FLUSH) && adv);
      emit_zero = (orow == '0) || o_last_row || (ocol == '0) || o_last_col;
      emit_sof  = (orow == '0) && (ocol == '0);
      emit_eol  = o_last_col;
      in_col    = icol;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         icol  <= '0;
         irow  <= '0;
         ocol  <= '0;
         orow  <= '0;
         phase <= PH_FEED;
      end else begin
         if (take) begin
            if (in_last_col) begin
               icol <= '0;
               irow <= in_last ? '0 : irow + RW'(1);
            end else begin
               icol <= icol + CW'(1);
            end
            if (in_last) begin
               phase <= PH_FLUSH;
            end
         end
         if (emit) begin
            if (o_last_col) begin
               ocol <= '0;
               orow <= o_last_row ? '0 : orow + RW'(1);
            end else begin
               ocol <= ocol + CW'(1);
            end
            if (o_last) begin
               phase <= PH_FEED;
            end
         end
      end
   end

   // R3
   sof_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_sof) |-> (irow == '0 && icol == '0));

   // R3
   eol_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (in_eol == in_last_col));

   // R6
   flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_last) |=> !in_ready);

   // R7
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && phase == PH_FEED) |->
         (int'(orow) * IMG_W + int'(ocol) + IMG_W + 1 == int'(irow) * IMG_W + int'(icol)));

endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
   import sobel_pkg::*;
#(
   parameter int IMG_W     = 600,
   parameter int IMG_H     = 400,
   parameter int PIX_W     = 8,
   parameter int MAG_SHIFT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [PIX_W-1:0] in_data,
   input  logic             in_sof,
   input  logic             in_eol,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [PIX_W-1:0] out_data,
   output logic             out_sof,
   output logic             out_eol
);

   localparam int CW = $clog2(IMG_W);

   if (IMG_W < WIN_SIDE || IMG_H < WIN_SIDE) begin : g_bad_size
      $error("sobel_edge_stream: image must be at least 3x3");
   end
   if (PIX_W < 1) begin : g_bad_pix
      $error("sobel_edge_stream: PIX_W must be positive");
   end

   logic          take, adv, emit, emit_zero, emit_sof, emit_eol;
   logic [CW-1:0] in_col;
   logic [LINE_CNT-1:0][PIX_W-1:0] taps;
   logic [PIX_W-1:0] mag;

   sobel_raster_ctl #(
      .IMG_W (IMG_W),
      .IMG_H (IMG_H)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_eol    (in_eol),
      .out_ready (out_ready),
      .out_busy  (out_valid),
      .in_ready  (in_ready),
      .take      (take),
      .adv       (adv),
      .emit      (emit),
      .emit_zero (emit_zero),
      .emit_sof  (emit_sof),
      .emit_eol  (emit_eol),
      .in_col    (in_col)
   );

   sobel_line_store #(
      .IMG_W (IMG_W),
      .PIX_W (PIX_W),
      .LINES (LINE_CNT)
   ) u_lines (
      .clk    (clk),
      .wr_en  (take),
      .col    (in_col),
      .pix_in (in_data),
      .taps   (taps)
   );

   // Column registers: col_m is one column back, col_l two columns back.
   // Index 0 is the top row of the neighbourhood.
   logic [WIN_SIDE-1:0][PIX_W-1:0] col_l, col_m, col_n;
   logic [2:0][2:0][PIX_W-1:0]     win;

   always_comb begin
      for (int r = 0; r < WIN_SIDE; r++) begin
         if (r == WIN_SIDE - 1) begin
            col_n[r] = in_data;
         end else begin
            col_n[r] = taps[LINE_CNT - 1 - r];
         end
         win[r][0] = col_l[r];
         win[r][1] = col_m[r];
         win[r][2] = col_n[r];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_l <= '0;
         col_m <= '0;
      end else if (take) begin
         col_l <= col_m;
         col_m <= col_n;
      end
   end

   sobel_kernel #(
      .PIX_W     (PIX_W),
      .MAG_SHIFT (MAG_SHIFT)
   ) u_kernel (
      .win (win),
      .mag (mag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
      end else if (adv) begin
         out_valid <= emit;
         out_data  <= emit_zero ? '0 : mag;
         out_sof   <= emit_sof;
         out_eol   <= emit_eol;
      end
   end

   // R4
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol)));

   // R5
   backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R2
   edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_sof || out_eol)) |-> (out_data == '0));

   // R8
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));

endmodule

// File: tb/tb_sobel_edge_stream.sv
`timescale 1ns/1ps
module tb_sobel_edge_stream;

   localparam int W  = 6;
   localparam int H  = 5;
   localparam int N  = W * H;
   localparam int SH = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = '0;
   logic       in_sof = 1'b0;
   logic       in_eol = 1'b0;
   logic       out_valid;
   logic       out_ready = 1'b0;
   logic [7:0] out_data;
   logic       out_sof;
   logic       out_eol;

   always #2.5 clk = ~clk;

   sobel_edge_stream #(
      .IMG_W     (W),
      .IMG_H     (H),
      .PIX_W     (8),
      .MAG_SHIFT (SH)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_sof    (in_sof),
      .in_eol    (in_eol),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_sof   (out_sof),
      .out_eol   (out_eol)
   );

   int          img [N];
   int          checks = 0;
   int          fails  = 0;
   int          cyc    = 0;
   bit          wd     = 1'b0;
   logic [15:0] lf     = 16'hACE1;

   task automatic chk(input bit ok, input string req, input int act, input int exp,
                      input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int px(input int r, input int c);
      return img[r * W + c];
   endfunction

   function automatic bit on_ring(input int r, input int c);
      return (r == 0) || (r == H - 1) || (c == 0) || (c == W - 1);
   endfunction

   // R1/R2 reference
   function automatic int expect_pix(input int r, input int c);
      int dx, dy;
      if (on_ring(r, c)) return 0;
      dx = (px(r-1, c+1) + 2 * px(r, c+1) + px(r+1, c+1))
         - (px(r-1, c-1) + 2 * px(r, c-1) + px(r+1, c-1));
      dy = (px(r-1, c-1) + 2 * px(r-1, c) + px(r-1, c+1))
         - (px(r+1, c-1) + 2 * px(r+1, c) + px(r+1, c+1));
      if (dx < 0) dx = -dx;
      if (dy < 0) dy = -dy;
      return ((dx + dy) >> SH) & 255;
   endfunction

   task automatic fill(input int pat, input int seed);
      for (int i = 0; i < N; i++) begin
         int r, c;
         r = i / W;
         c = i % W;
         case (pat)
            0: img[i] = (r * 37 + c * 53 + seed) & 255;
            1: img[i] = (i * 73 + seed * 151 + i * i * 19) & 255;
            2: img[i] = ((r + c) % 2 == 1) ? 255 : 0;
            3: img[i] = (c >= W / 2) ? 255 : 0;
            4: img[i] = (r >= H / 2) ? 255 : 0;
            5: img[i] = 255;
            default: img[i] = (r == 2 && c == 3) ? 255 : 0;
         endcase
      end
   endtask

   task automatic step_lfsr();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   task automatic run_frame(input int mode);
      int   ip = 0;
      int   op = 0;
      bit   hold_pend = 1'b0;
      int   hold_data = 0;
      while (op < N && !wd) begin
         int ip0, r, c, e;
         @(negedge clk);
         cyc++;
         if (cyc > 150000) begin
            wd = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            break;
         end
         step_lfsr();
         if (ip < N) begin
            in_valid = (mode & 1) ? (lf[0] | lf[3]) : 1'b1;
            in_data  = 8'(img[ip]);
            in_sof   = (ip == 0);
            in_eol   = ((ip % W) == W - 1);
         end else if (op < N - 1) begin
            in_valid = 1'b1;
            in_data  = 8'hA5;
            in_sof   = 1'b0;
            in_eol   = 1'b0;
         end else begin
            in_valid = 1'b0;
         end
         out_ready = (mode & 2) ? (lf[5] | lf[9]) : 1'b1;
         #1;
         if (hold_pend) begin
            // R4: output held while stalled
            chk(out_valid && (int'(out_data) == hold_data), "R4", int'(out_data), hold_data,
                "held output data");
            hold_pend = 1'b0;
         end
         if (ip >= N && op < N - 1 && in_valid) begin
            // R6: no input taken while the frame drains
            chk(in_ready == 1'b0, "R6", int'(in_ready), 0, "in_ready during drain");
         end
         if (out_valid && !out_ready) begin
            // R5: backpressure stalls input
            chk(in_ready == 1'b0, "R5", int'(in_ready), 0, "in_ready under backpressure");
            hold_pend = 1'b1;
            hold_data = int'(out_data);
         end
         ip0 = ip;
         if (in_valid && in_ready && ip < N) ip++;
         if (out_valid && out_ready) begin
            r = op / W;
            c = op % W;
            e = expect_pix(r, c);
            if (on_ring(r, c))
               chk(int'(out_data) == e, "R2", int'(out_data), e, "ring pixel");
            else
               chk(int'(out_data) == e, "R1", int'(out_data), e, "interior magnitude");
            chk(out_sof == (op == 0), "R3", int'(out_sof), int'(op == 0), "out_sof");
            chk(out_eol == (c == W - 1), "R3", int'(out_eol), int'(c == W - 1), "out_eol");
            if (op < N - W - 1) begin
               // R7: output trails input by a row plus one pixel
               chk(ip0 >= op + W + 2, "R7", ip0, op + W + 2, "inputs before output");
            end
            op++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      // R3: one output per input pixel
      chk(op == N, "R3", op, N, "outputs per frame");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8: state after reset
      chk(out_valid == 1'b0, "R8", int'(out_valid), 0, "out_valid after reset");
      chk(in_ready == 1'b1, "R8", int'(in_ready), 1, "in_ready after reset");

      // Partial frame, then reset in the middle of it.
      fill(1, 7);
      begin
         int fed = 0;
         out_ready = 1'b1;
         while (fed < 10 && !wd) begin
            @(negedge clk);
            cyc++;
            in_valid = 1'b1;
            in_data  = 8'(img[fed]);
            in_sof   = (fed == 0);
            in_eol   = ((fed % W) == W - 1);
            #1;
            if (in_ready) fed++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst_n    = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R8: mid-frame reset returns to frame start
      chk(out_valid == 1'b0, "R8", int'(out_valid), 0, "out_valid after mid-frame reset");
      chk(in_ready == 1'b1, "R8", int'(in_ready), 1, "in_ready after mid-frame reset");

      for (int f = 0; f < 28 && !wd; f++) begin
         fill(f % 7, f);
         run_frame(f % 4);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule